// File: doc/BRIEF.md
# Microcoded Instruction Control Sequencer

This block produces the control word that steers a small accumulator processor for every clock cycle. A three-bit step counter walks through five steps per instruction, T0 to T4, and then wraps. The word is looked up combinationally from the current step, the 4-bit opcode held in the instruction register, and the latched carry and zero flags. The first two steps of every instruction fetch the next instruction. The remaining steps carry out the opcode's own work. Any step that an instruction leaves unused outputs an all-zero word.

The lookup table is computed at elaboration. It is indexed by opcode, step, carry and zero together, so the conditional jumps are resolved by the table entry and not by separate branch logic. The datapath modules decode each output bit at a fixed position. Once the halt bit is issued, the sequencer freezes until reset.

Control bit positions (a word is the OR of its active bits):
- bit0 halt = 0x0001
- bit1 address-register load = 0x0002
- bit2 memory drive = 0x0004
- bit3 memory write = 0x0008
- bit4 operand-nibble drive = 0x0010
- bit5 instruction-register load = 0x0020
- bit6 accumulator drive = 0x0040
- bit7 accumulator load = 0x0080
- bit8 ALU drive = 0x0100
- bit9 ALU subtract = 0x0200
- bit10 B-register load = 0x0400
- bit11 display load = 0x0800
- bit12 PC increment = 0x1000
- bit13 PC drive = 0x2000
- bit14 PC load = 0x4000
- bit15 flag capture = 0x8000

Top module: `ucode_sequencer`

## Requirements
- R1: In step T0 the word is 0x2002, and in step T1 it is 0x1024, for every opcode and flag value.
- R2: The step counter advances by one on each rising edge from T0 to T4 and then returns to T0, so every instruction takes five clocks.
- R3: Opcode 0x0 and opcodes 0x9 to 0xD output 0x0000 in T2, T3 and T4. Every step that an opcode below does not list also outputs 0x0000.
- R4: Opcode 0x1 (load accumulator from memory) outputs 0x0012 in T2 and 0x0084 in T3.
- R5: Opcode 0x4 (store accumulator) outputs 0x0012 in T2 and 0x0048 in T3.
- R6: Opcode 0x2 (add) outputs 0x0012 in T2, 0x0404 in T3 and 0x8180 in T4.
- R7: Opcode 0x3 (subtract) matches opcode 0x2, except that T4 outputs 0x8380, which adds the subtract bit.
- R8: Opcode 0x5 (load immediate) outputs 0x0090 in T2. Opcode 0x6 (jump) outputs 0x4010 in T2.
- R9: Opcode 0x7 outputs 0x4010 in T2 only when flag_carry is 1, and 0x0000 otherwise. Opcode 0x8 does the same using flag_zero. The flag that an opcode does not test has no effect.
- R10: Opcode 0xE (display accumulator) outputs 0x0840 in T2.
- R11: Opcode 0xF outputs 0x0001 in T2. From then on, the word stays 0x0001 for any opcode or flag value until reset.
- R12: While rst_n is low, the counter is forced to T0 at once and the word is 0x2002. After rst_n rises, the counter stays at T0 until the third rising edge, then resumes R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| opcode | input | 4 | Opcode field of the instruction register |
| flag_zero | input | 1 | Latched zero flag |
| flag_carry | input | 1 | Latched carry flag |
| ctrl_word | output | 16 | Control word for the current step |

## Verification
The only internal state is the step counter and the halt latch. A wrong step value shows on ctrl_word in the same cycle, as a fetch word in the wrong place or an execute word shifted by one clock. A counter that fails to wrap after T4 shows within one clock, because the next fetch word does not appear. A halt latch that fails to hold shows on the first edge after 0x0001 is issued, when the word leaves the halt value. Flag mistakes appear only in T2 of the two conditional jumps, so each flag is driven both ways in that step.

// File: rtl/useq_pkg.sv
package useq_pkg;

  localparam int unsigned CW_W   = 16;
  localparam int unsigned OP_W   = 4;
  localparam int unsigned STEPS  = 5;
  localparam int unsigned STEP_W = $clog2(STEPS);

  typedef logic [CW_W-1:0]   cword_t;
  typedef logic [STEP_W-1:0] step_t;

  typedef enum logic [OP_W-1:0] {
    OP_NOP   = 4'h0,
    OP_LDM   = 4'h1,
    OP_ADD   = 4'h2,
    OP_SUB   = 4'h3,
    OP_STM   = 4'h4,
    OP_LDIMM = 4'h5,
    OP_JUMP  = 4'h6,
    OP_JCY   = 4'h7,
    OP_JZR   = 4'h8,
    OP_SHOW  = 4'hE,
    OP_STOP  = 4'hF
  } opcode_e;

  // Fixed bit positions decoded by the datapath.
  localparam cword_t C_HALT  = 16'h0001;
  localparam cword_t C_ADRLD = 16'h0002;
  localparam cword_t C_MEMDR = 16'h0004;
  localparam cword_t C_MEMWR = 16'h0008;
  localparam cword_t C_NIBDR = 16'h0010;
  localparam cword_t C_IRLD  = 16'h0020;
  localparam cword_t C_ACCDR = 16'h0040;
  localparam cword_t C_ACCLD = 16'h0080;
  localparam cword_t C_ALUDR = 16'h0100;
  localparam cword_t C_ALUSB = 16'h0200;
  localparam cword_t C_OPBLD = 16'h0400;
  localparam cword_t C_DSPLD = 16'h0800;
  localparam cword_t C_PCINC = 16'h1000;
  localparam cword_t C_PCDR  = 16'h2000;
  localparam cword_t C_PCLD  = 16'h4000;
  localparam cword_t C_FLGLD = 16'h8000;

  localparam cword_t FETCH0 = C_PCDR | C_ADRLD;
  localparam cword_t FETCH1 = C_MEMDR | C_IRLD | C_PCINC;

  // One microcode entry, indexed by opcode, step and both flags.
  function automatic cword_t ucode_word(input logic [OP_W-1:0] op,
                                        input step_t st,
                                        input logic cf,
                                        input logic zf);
    cword_t w;
    w = '0;
    if (st == 3'd0) begin
      w = FETCH0;
    end else if (st == 3'd1) begin
      w = FETCH1;
    end else begin
      case (op)
        OP_LDM: begin
          if (st == 3'd2) w = C_NIBDR | C_ADRLD;
          if (st == 3'd3) w = C_MEMDR | C_ACCLD;
        end
        OP_STM: begin
          if (st == 3'd2) w = C_NIBDR | C_ADRLD;
          if (st == 3'd3) w = C_ACCDR | C_MEMWR;
        end
        OP_ADD, OP_SUB: begin
          if (st == 3'd2) w = C_NIBDR | C_ADRLD;
          if (st == 3'd3) w = C_MEMDR | C_OPBLD;
          if (st == 3'd4) begin
            w = C_ALUDR | C_ACCLD | C_FLGLD;
            if (op == OP_SUB) w = w | C_ALUSB;
          end
        end
        OP_LDIMM: if (st == 3'd2) w = C_NIBDR | C_ACCLD;
        OP_JUMP:  if (st == 3'd2) w = C_NIBDR | C_PCLD;
        OP_JCY:   if (st == 3'd2 && cf) w = C_NIBDR | C_PCLD;
        OP_JZR:   if (st == 3'd2 && zf) w = C_NIBDR | C_PCLD;
        OP_SHOW:  if (st == 3'd2) w = C_ACCDR | C_DSPLD;
        OP_STOP:  if (st == 3'd2) w = C_HALT;
        default:  w = '0;
      endcase
    end
    return w;
  endfunction

endpackage

// File: rtl/useq_reset_sync.sv
module useq_reset_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/useq_step_counter.sv
module useq_step_counter
  import useq_pkg::*;
#(
  parameter int unsigned NSTEP = STEPS,
  localparam int unsigned SW   = $clog2(NSTEP),
  localparam logic [SW-1:0] LAST = SW'(NSTEP - 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hold,
  output logic [SW-1:0] step
);

  logic [SW-1:0] step_q;
  logic [SW-1:0] step_d;
  logic          step_en;

  always_comb begin
    step_en = !hold;
    step_d  = (step_q == LAST) ? '0 : step_q + SW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       step_q <= '0;
    else if (step_en) step_q <= step_d;
  end

  assign step = step_q;

endmodule

// File: rtl/useq_rom.sv
module useq_rom
  import useq_pkg::*;
#(
  parameter int unsigned OPW = OP_W,
  parameter int unsigned SW  = STEP_W,
  parameter int unsigned CWW = CW_W,
  localparam int unsigned AW    = OPW + SW + 2,
  localparam int unsigned DEPTH = 1 << AW
) (
  input  logic [OPW-1:0] op,
  input  logic [SW-1:0]  step,
  input  logic           carry,
  input  logic           zero,
  output logic [CWW-1:0] word
);

  logic [CWW-1:0] tbl [DEPTH];
  logic [AW-1:0]  addr;

  for (genvar a = 0; a < DEPTH; a++) begin : g_entry
    localparam logic [AW-1:0] A = AW'(a);
    assign tbl[a] = CWW'(ucode_word(A[AW-1 -: OPW], A[SW+1:2], A[1], A[0]));
  end

  always_comb begin
    addr = {op, step, carry, zero};
    word = tbl[addr];
  end

endmodule

// File: rtl/ucode_sequencer.sv
module ucode_sequencer
  import useq_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [3:0]  opcode,
  input  logic        flag_zero,
  input  logic        flag_carry,
  output logic [15:0] ctrl_word
);

  logic          rst_int_n;
  step_t         step_q;
  cword_t        rom_word;
  logic          halted_q;
  logic          halted_d;
  logic          freeze;

  useq_reset_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  useq_step_counter #(.NSTEP(STEPS)) u_cnt (
    .clk   (clk),
    .rst_n (rst_int_n),
    .hold  (freeze),
    .step  (step_q)
  );

  useq_rom #(.OPW(OP_W), .SW(STEP_W), .CWW(CW_W)) u_rom (
    .op    (opcode),
    .step  (step_q),
    .carry (flag_carry),
    .zero  (flag_zero),
    .word  (rom_word)
  );

  always_comb begin
    halted_d  = halted_q | rom_word[0];
    freeze    = halted_d;
    ctrl_word = halted_q ? C_HALT : rom_word;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) halted_q <= 1'b0;
    else            halted_q <= halted_d;
  end

endmodule

// File: rtl/useq_checker.sv
module useq_checker (
  input logic        clk,
  input logic        rst_int_n,
  input logic [3:0]  opcode,
  input logic        flag_carry,
  input logic [15:0] ctrl_word,
  input logic [2:0]  step,
  input logic        halted
);

  p_step_range_r2: assert property (@(posedge clk) disable iff (!rst_int_n)
    step <= 3'd4);

  p_step_inc_r2: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!ctrl_word[0] && step != 3'd4) |=> (step == $past(step) + 3'd1));

  p_step_wrap_r2: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!ctrl_word[0] && step == 3'd4) |=> (step == 3'd0));

  p_fetch_r1: assert property (@(posedge clk) disable iff (!rst_int_n)
    (step == 3'd0 && !halted) |-> (ctrl_word == 16'h2002));

  p_unused_r3: assert property (@(posedge clk) disable iff (!rst_int_n)
    (step >= 3'd2 && !halted && (opcode == 4'h0 || (opcode >= 4'h9 && opcode <= 4'hD)))
      |-> (ctrl_word == 16'h0000));

  p_jc_clear_r9: assert property (@(posedge clk) disable iff (!rst_int_n)
    (step == 3'd2 && opcode == 4'h7 && !flag_carry && !halted) |-> (ctrl_word == 16'h0000));

  p_halt_hold_r11: assert property (@(posedge clk) disable iff (!rst_int_n)
    ctrl_word[0] |=> (ctrl_word == 16'h0001 && $stable(step)));

endmodule

bind ucode_sequencer useq_checker chk_i (
  .clk        (clk),
  .rst_int_n  (rst_int_n),
  .opcode     (opcode),
  .flag_carry (flag_carry),
  .ctrl_word  (ctrl_word),
  .step       (step_q),
  .halted     (halted_q)
);

// File: tb/ucode_sequencer_tb_top.sv
module ucode_sequencer_tb_top;

  logic        clk;
  logic        rst_n;
  logic [3:0]  opcode;
  logic        flag_zero;
  logic        flag_carry;
  logic [15:0] ctrl_word;

  int n_chk;
  int n_bad;

  ucode_sequencer dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .opcode     (opcode),
    .flag_zero  (flag_zero),
    .flag_carry (flag_carry),
    .ctrl_word  (ctrl_word)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input string req, input logic [15:0] exp);
    n_chk++;
    if (ctrl_word !== exp) begin
      n_bad++;
      $display("FAIL %s: ctrl_word=%h expected=%h", req, ctrl_word, exp);
    end
  endtask

  // Reset, then wait at a falling edge where the counter is still at T0.
  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    #1 check("R12 in reset", 16'h2002);
    repeat (2) @(negedge clk);
    check("R12 held reset", 16'h2002);
    rst_n = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R12 T0 after release", 16'h2002);
  endtask

  // Run one five-step instruction, starting at a falling edge in T0.
  task automatic run_instr(input string req, input logic [3:0] op,
                           input logic cf, input logic zf,
                           input logic [15:0] e2, input logic [15:0] e3,
                           input logic [15:0] e4);
    logic [15:0] exp [5];
    exp[0] = 16'h2002; exp[1] = 16'h1024;
    exp[2] = e2; exp[3] = e3; exp[4] = e4;
    opcode = op; flag_carry = cf; flag_zero = zf;
    for (int s = 0; s < 5; s++) begin
      #1;
      check((s < 2) ? {req, " R1/R2 fetch"} : req, exp[s]);
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic test_unused();
    run_instr("R3 nop", 4'h0, 1'b1, 1'b1, 16'h0, 16'h0, 16'h0);
    for (int op = 9; op <= 13; op++)
      run_instr("R3 unused op", 4'(op), 1'b1, 1'b0, 16'h0, 16'h0, 16'h0);
  endtask

  task automatic test_memory();
    run_instr("R4 load", 4'h1, 1'b0, 1'b0, 16'h0012, 16'h0084, 16'h0);
    run_instr("R5 store", 4'h4, 1'b1, 1'b1, 16'h0012, 16'h0048, 16'h0);
  endtask

  task automatic test_alu();
    run_instr("R6 add", 4'h2, 1'b0, 1'b0, 16'h0012, 16'h0404, 16'h8180);
    run_instr("R7 sub", 4'h3, 1'b1, 1'b0, 16'h0012, 16'h0404, 16'h8380);
  endtask

  task automatic test_imm_jump();
    run_instr("R8 ldimm", 4'h5, 1'b0, 1'b0, 16'h0090, 16'h0, 16'h0);
    run_instr("R8 jump", 4'h6, 1'b0, 1'b0, 16'h4010, 16'h0, 16'h0);
  endtask

  task automatic test_cond();
    run_instr("R9 jc taken", 4'h7, 1'b1, 1'b0, 16'h4010, 16'h0, 16'h0);
    run_instr("R9 jc not taken zero ignored", 4'h7, 1'b0, 1'b1, 16'h0, 16'h0, 16'h0);
    run_instr("R9 jz taken", 4'h8, 1'b0, 1'b1, 16'h4010, 16'h0, 16'h0);
    run_instr("R9 jz not taken carry ignored", 4'h8, 1'b1, 1'b0, 16'h0, 16'h0, 16'h0);
  endtask

  task automatic test_show();
    run_instr("R10 display", 4'hE, 1'b0, 1'b1, 16'h0840, 16'h0, 16'h0);
  endtask

  task automatic test_halt();
    opcode = 4'hF; flag_carry = 1'b0; flag_zero = 1'b0;
    #1 check("R11 T0", 16'h2002);
    @(posedge clk); @(negedge clk);
    check("R11 T1", 16'h1024);
    @(posedge clk); @(negedge clk);
    check("R11 halt issued", 16'h0001);
    for (int i = 0; i < 8; i++) begin
      @(posedge clk); @(negedge clk);
      opcode = 4'(i + 1); flag_carry = i[0]; flag_zero = i[1];
      #1 check("R11 halt held", 16'h0001);
    end
    do_reset();
    run_instr("R11 recovery after reset", 4'h6, 1'b0, 1'b0, 16'h4010, 16'h0, 16'h0);
  endtask

  task automatic test_midreset();
    opcode = 4'h2;
    @(posedge clk); @(negedge clk);
    @(posedge clk); @(negedge clk);
    #1 check("R12 pre-reset T2", 16'h0012);
    do_reset();
    run_instr("R12 resume", 4'h2, 1'b0, 1'b0, 16'h0012, 16'h0404, 16'h8180);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    n_chk = 0; n_bad = 0;
    rst_n = 1'b0; opcode = 4'h0; flag_zero = 1'b0; flag_carry = 1'b0;
    do_reset();
    test_unused();
    test_memory();
    test_alu();
    test_imm_jump();
    test_cond();
    test_show();
    test_midreset();
    test_halt();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule